// File: doc/BRIEF.md
# Synchronous Dataflow Firing Controller

This block sequences a small, fixed synchronous dataflow graph in hardware. The graph's actors sit outside the block. Each actor is reached through a one-cycle start strobe, and it reports back with a one-cycle completion pulse. Actors are joined by one-way arcs. Each arc has one producing actor and one consuming actor. For every arc, parameters set the tokens produced per firing, the tokens consumed per firing, the token count after reset (the arc's delay) and a capacity. The block stores only how many tokens each arc holds. It never stores the data itself.

Each cycle the block works out which actors are ready to fire. An actor is ready when all of the following hold: every input arc holds enough tokens, every output arc has room for what the actor will produce, the actor is not already running, and the global permit is high. The lowest-numbered ready actor gets a start strobe. Input tokens are taken when the strobe is issued. Output tokens are added when the completion pulse arrives. If an update would push an arc outside zero to capacity, the update is dropped and a sticky error flag is set. Arc counts and per-actor firing counters are brought out, so that token balance over a schedule period can be checked from outside.

The default graph has three actors. Actor 0 is a source that produces 2 tokens onto arc 0. Actor 1 takes 3 tokens from arc 0 and 1 token from arc 2, and produces 1 token onto arc 1. Actor 2 takes 2 tokens from arc 1 and produces 2 tokens onto arc 2. The capacities of arcs 0, 1 and 2 are 6, 4 and 2. Arc 2 starts with 2 tokens and the other arcs start empty. One balanced period fires the three actors 3, 2 and 1 times.

Top module: `sdf_fire_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, every arc count equals that arc's delay (default 0, 0, 2), every firing counter is zero, `fire_o` is zero and `err_o` is low.
- R2: An actor with no input arcs is ready whenever it is idle, the permit is high and its output arcs have room.
- R3: An actor is never strobed unless each of its input arcs held at least that arc's consumption count in the cycle before the strobe.
- R4: An actor is held off while any of its output arcs has a count plus production count above that arc's capacity.
- R5: At most one bit of `fire_o` is high in any cycle. When several actors are ready, the lowest index is strobed.
- R6: A strobe lasts one cycle. The consumption counts are subtracted from the actor's input arcs in the same cycle that the strobe appears.
- R7: A high `done_i[a]` sampled on a clock edge adds the production counts to actor a's output arcs in the next cycle and frees the actor. A busy actor is not strobed again until its done is sampled.
- R8: If the combined update to an arc in a cycle would leave it below zero or above capacity, the count keeps its old value and `err_o` goes high and stays high until reset.
- R9: `fire_cnt_o[a*FCW +: FCW]` counts the strobes of actor a, modulo 2^FCW.
- R10: While `fire_en_i` is low, no strobe is issued in the following cycle. Completion pulses are still applied.
- R11: Over any run, each arc count equals its delay, plus its production count times the producer's sampled done pulses, minus its consumption count times the consumer's strobes. The counts therefore return to the delays after a balanced period with no firing in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_en_i | input | 1 | Permit to start new firings |
| done_i | input | NACT | Per-actor completion pulse |
| fire_o | output | NACT | Per-actor one-cycle start strobe |
| arc_cnt_o | output | NARC*CW | Token count of arc k at bits [k*CW +: CW] |
| fire_cnt_o | output | NACT*FCW | Firing counter of actor a at bits [a*FCW +: FCW] |
| err_o | output | 1 | Sticky out-of-range update flag |

## Verification
The bench builds the block with the default three-actor graph, 4-bit arc counts and the firing counter narrowed to FCW = 4. With the narrow counter, wrap-around is reached within a few hundred cycles of free running. The default graph includes a feedback arc with a two-token delay, a source limited only by capacity, and a multi-rate consumer, so one scripted sequence can reach priority ties, capacity stalls, token stalls, and a credit and a debit landing on the same arc in the same cycle. Overflow is produced with completion pulses that have no matching firing.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

   // Elaboration-time sanity test for one arc's parameter set.
   function automatic bit arc_params_ok(input int cw, input int prod, input int cons,
                                        input int init, input int cap);
      return (prod >= 1) && (cons >= 1) && (prod <= cap) && (cons <= cap) &&
             (init >= 0) && (init <= cap) && (cap < (1 << cw));
   endfunction

   // Arc endpoints must name two distinct, existing actors.
   function automatic bit arc_ends_ok(input int nact, input int src, input int dst);
      return (src >= 0) && (dst >= 0) && (src < nact) && (dst < nact) && (src != dst);
   endfunction

endpackage

// File: rtl/sdf_arc_ctr.sv
module sdf_arc_ctr #(
   parameter int CW   = 4,
   parameter int PROD = 1,
   parameter int CONS = 1,
   parameter int INIT = 0,
   parameter int CAP  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          debit_i,
   input  logic          credit_i,
   output logic [CW-1:0] cnt_o,
   output logic          avail_o,
   output logic          room_o,
   output logic          bad_o
);

   logic [CW-1:0] cnt_q;
   int            nxt;

   always_comb begin
      nxt = int'(cnt_q);
      if (credit_i) nxt = nxt + PROD;
      if (debit_i)  nxt = nxt - CONS;
   end

   assign bad_o   = (nxt < 0) || (nxt > CAP);
   assign avail_o = (int'(cnt_q) >= CONS);
   assign room_o  = (int'(cnt_q) + PROD) <= CAP;
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= CW'(INIT);
      else if (!bad_o) cnt_q <= CW'(nxt);
   end

   // R8: a rejected update leaves the count untouched
   p_hold_on_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_o |=> $stable(cnt_o));
   // R4: the count never leaves its legal range
   p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_o) <= CAP);

endmodule

// File: rtl/sdf_actor_slot.sv
module sdf_actor_slot #(
   parameter int FCW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           grant_i,
   input  logic           done_i,
   output logic           busy_o,
   output logic           fire_o,
   output logic [FCW-1:0] fcnt_o
);

   logic           busy_q;
   logic           fire_q;
   logic [FCW-1:0] fcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         fire_q <= 1'b0;
         fcnt_q <= '0;
      end else begin
         fire_q <= grant_i;
         if (grant_i)     busy_q <= 1'b1;
         else if (done_i) busy_q <= 1'b0;
         if (grant_i)     fcnt_q <= fcnt_q + 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign fire_o = fire_q;
   assign fcnt_o = fcnt_q;

   // R7: a running actor is not restarted before its done pulse
   p_no_refire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_i) |=> !fire_o);
   // R6: the start strobe lasts exactly one cycle
   p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);

endmodule

// File: rtl/sdf_ready_logic.sv
module sdf_ready_logic #(
   parameter int NACT = 3,
   parameter int NARC = 3,
   parameter int ARC_SRC [NARC] = '{default: 0},
   parameter int ARC_DST [NARC] = '{default: 1}
) (
   input  logic            en_i,
   input  logic [NACT-1:0] busy_i,
   input  logic [NARC-1:0] avail_i,
   input  logic [NARC-1:0] room_i,
   output logic [NACT-1:0] ready_o
);

   for (genvar a = 0; a < NACT; a++) begin : g_act
      logic in_ok;
      logic out_ok;
      always_comb begin
         in_ok  = 1'b1;
         out_ok = 1'b1;
         for (int k = 0; k < NARC; k++) begin
            if (ARC_DST[k] == a) in_ok  = in_ok  & avail_i[k];
            if (ARC_SRC[k] == a) out_ok = out_ok & room_i[k];
         end
      end
      assign ready_o[a] = en_i & ~busy_i[a] & in_ok & out_ok;
   end

endmodule

// File: rtl/sdf_prio_pick.sv
module sdf_prio_pick #(
   parameter int N = 3
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o
);

   // isolate lowest set bit: lowest index wins
   assign gnt_o = req_i & (~req_i + 1'b1);

   always_comb begin
      if (gnt_o != '0) assert ((req_i & (gnt_o - 1'b1)) == '0);
   end

endmodule

// File: rtl/sdf_fire_ctrl.sv
module sdf_fire_ctrl #(
   parameter int NACT = 3,
   parameter int NARC = 3,
   parameter int CW   = 4,
   parameter int FCW  = 8,
   parameter int ARC_SRC  [NARC] = '{0, 1, 2},
   parameter int ARC_DST  [NARC] = '{1, 2, 1},
   parameter int ARC_PROD [NARC] = '{2, 1, 2},
   parameter int ARC_CONS [NARC] = '{3, 2, 1},
   parameter int ARC_INIT [NARC] = '{0, 0, 2},
   parameter int ARC_CAP  [NARC] = '{6, 4, 2}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire_en_i,
   input  logic [NACT-1:0]      done_i,
   output logic [NACT-1:0]      fire_o,
   output logic [NARC*CW-1:0]   arc_cnt_o,
   output logic [NACT*FCW-1:0]  fire_cnt_o,
   output logic                 err_o
);
   import sdf_pkg::*;

   if (NACT < 1 || NACT > 32) begin : g_bad_nact
      $error("sdf_fire_ctrl: NACT out of range");
   end
   if (NARC < 1 || CW < 2 || FCW < 1) begin : g_bad_width
      $error("sdf_fire_ctrl: width or arc count out of range");
   end

   logic [NACT-1:0] busy;
   logic [NACT-1:0] ready;
   logic [NACT-1:0] grant;
   logic [NARC-1:0] avail;
   logic [NARC-1:0] room;
   logic [NARC-1:0] bad;
   logic [NARC-1:0] debit;
   logic [NARC-1:0] credit;
   logic            err_q;

   for (genvar k = 0; k < NARC; k++) begin : g_arc
      if (!arc_params_ok(CW, ARC_PROD[k], ARC_CONS[k], ARC_INIT[k], ARC_CAP[k])) begin : g_chk_rate
         $error("sdf_fire_ctrl: arc rate, delay or capacity invalid");
      end
      if (!arc_ends_ok(NACT, ARC_SRC[k], ARC_DST[k])) begin : g_chk_ends
         $error("sdf_fire_ctrl: arc endpoints invalid");
      end

      assign debit[k]  = grant[ARC_DST[k]];
      assign credit[k] = done_i[ARC_SRC[k]];

      sdf_arc_ctr #(
         .CW  (CW),
         .PROD(ARC_PROD[k]),
         .CONS(ARC_CONS[k]),
         .INIT(ARC_INIT[k]),
         .CAP (ARC_CAP[k])
      ) u_arc (
         .clk     (clk),
         .rst_n   (rst_n),
         .debit_i (debit[k]),
         .credit_i(credit[k]),
         .cnt_o   (arc_cnt_o[k*CW +: CW]),
         .avail_o (avail[k]),
         .room_o  (room[k]),
         .bad_o   (bad[k])
      );

      // R3: a strobe only follows a cycle with enough input tokens
      p_fire_needs_tokens_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fire_o[ARC_DST[k]] |-> int'($past(arc_cnt_o[k*CW +: CW])) >= ARC_CONS[k]);
   end

   sdf_ready_logic #(
      .NACT   (NACT),
      .NARC   (NARC),
      .ARC_SRC(ARC_SRC),
      .ARC_DST(ARC_DST)
   ) u_ready (
      .en_i   (fire_en_i),
      .busy_i (busy),
      .avail_i(avail),
      .room_i (room),
      .ready_o(ready)
   );

   sdf_prio_pick #(.N(NACT)) u_pick (
      .req_i(ready),
      .gnt_o(grant)
   );

   for (genvar a = 0; a < NACT; a++) begin : g_slot
      sdf_actor_slot #(.FCW(FCW)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .grant_i(grant[a]),
         .done_i (done_i[a]),
         .busy_o (busy[a]),
         .fire_o (fire_o[a]),
         .fcnt_o (fire_cnt_o[a*FCW +: FCW])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    err_q <= 1'b0;
      else if (|bad) err_q <= 1'b1;
   end
   assign err_o = err_q;

   // R5: never more than one start strobe per cycle
   p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fire_o));
   // R10: permit low means no strobe next cycle
   p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_en_i |=> (fire_o == '0));
   // R8: the error flag holds until reset
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

endmodule

// File: tb/sdf_fire_ctrl_bench.sv
`timescale 1ns/1ps
module sdf_fire_ctrl_bench;
   localparam int NACT = 3;
   localparam int NARC = 3;
   localparam int CW   = 4;
   localparam int FCW  = 4;
   localparam int NSTEP = 16;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                fire_en_i = 1'b0;
   logic [NACT-1:0]     done_i = '0;
   logic [NACT-1:0]     fire_o;
   logic [NARC*CW-1:0]  arc_cnt_o;
   logic [NACT*FCW-1:0] fire_cnt_o;
   logic                err_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sdf_fire_ctrl #(.NACT(NACT), .NARC(NARC), .CW(CW), .FCW(FCW)) u_sdf_fire_ctrl (
      .clk(clk), .rst_n(rst_n), .fire_en_i(fire_en_i), .done_i(done_i),
      .fire_o(fire_o), .arc_cnt_o(arc_cnt_o), .fire_cnt_o(fire_cnt_o), .err_o(err_o)
   );

   // {permit, done[2:0], expected fire[2:0], arc0, arc1, arc2} seen after the edge
   localparam logic [18:0] TBL [NSTEP] = '{
      {1'b1, 3'b000, 3'b001, 4'd0, 4'd0, 4'd2},  // R2 source starts
      {1'b1, 3'b001, 3'b000, 4'd2, 4'd0, 4'd2},  // R7 credit, R6 no repeat strobe
      {1'b1, 3'b000, 3'b001, 4'd2, 4'd0, 4'd2},
      {1'b1, 3'b001, 3'b000, 4'd4, 4'd0, 4'd2},
      {1'b1, 3'b000, 3'b001, 4'd4, 4'd0, 4'd2},  // R5 actors 0 and 1 tie, 0 wins
      {1'b1, 3'b001, 3'b010, 4'd3, 4'd0, 4'd1},  // R6 debit with same-cycle credit
      {1'b1, 3'b010, 3'b001, 4'd3, 4'd1, 4'd1},
      {1'b0, 3'b001, 3'b000, 4'd5, 4'd1, 4'd1},  // R10 permit low, done still applied
      {1'b1, 3'b000, 3'b010, 4'd2, 4'd1, 4'd0},  // R4 source stalled by capacity
      {1'b1, 3'b010, 3'b001, 4'd2, 4'd2, 4'd0},
      {1'b1, 3'b001, 3'b100, 4'd4, 4'd0, 4'd0},  // R3 actor 1 short of tokens
      {1'b0, 3'b100, 3'b000, 4'd4, 4'd0, 4'd2},
      {1'b1, 3'b000, 3'b001, 4'd4, 4'd0, 4'd2},
      {1'b0, 3'b001, 3'b000, 4'd6, 4'd0, 4'd2},
      {1'b1, 3'b000, 3'b010, 4'd3, 4'd0, 4'd1},  // R4 source full, actor 1 goes
      {1'b0, 3'b010, 3'b000, 4'd3, 4'd1, 4'd1}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int arc(input int k);
      return int'(arc_cnt_o[k*CW +: CW]);
   endfunction

   function automatic int fcnt(input int a);
      return int'(fire_cnt_o[a*FCW +: FCW]);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      fire_en_i = 1'b0;
      done_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic chk_reset_state();
      chk("R1", "arc0", arc(0), 0);
      chk("R1", "arc1", arc(1), 0);
      chk("R1", "arc2", arc(2), 2);
      chk("R1", "fire", int'(fire_o), 0);
      chk("R1", "err", int'(err_o), 0);
      for (int a = 0; a < NACT; a++) chk("R1", "fire count", fcnt(a), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state, checked during and just after reset
      repeat (2) @(negedge clk);
      chk_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset_state();

      // scripted table
      fire_en_i = TBL[0][18];
      done_i    = TBL[0][17:15];
      for (int i = 0; i < NSTEP; i++) begin
         @(negedge clk);
         chk("R5", $sformatf("step %0d fire", i), int'(fire_o), int'(TBL[i][14:12]));
         chk("R6", $sformatf("step %0d arc0", i), arc(0), int'(TBL[i][11:8]));
         chk("R7", $sformatf("step %0d arc1", i), arc(1), int'(TBL[i][7:4]));
         chk("R3", $sformatf("step %0d arc2", i), arc(2), int'(TBL[i][3:0]));
         if (i < NSTEP - 1) begin
            fire_en_i = TBL[i+1][18];
            done_i    = TBL[i+1][17:15];
         end
      end
      chk("R9", "table fire count a0", fcnt(0), 6);
      chk("R9", "table fire count a1", fcnt(1), 3);
      chk("R9", "table fire count a2", fcnt(2), 1);
      chk("R8", "table err", int'(err_o), 0);

      // free run with a responder: done one cycle after each strobe
      begin
         int f[NACT];
         int dn[NACT];
         for (int a = 0; a < NACT; a++) begin f[a] = 0; dn[a] = 0; end
         do_reset();
         fire_en_i = 1'b1;
         for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            for (int a = 0; a < NACT; a++) if (fire_o[a]) f[a]++;
            // R11 token conservation per arc
            chk("R11", "arc0 balance", arc(0), 2 * dn[0] - 3 * f[1]);
            chk("R11", "arc1 balance", arc(1), 1 * dn[1] - 2 * f[2]);
            chk("R11", "arc2 balance", arc(2), 2 + 2 * dn[2] - f[1]);
            for (int a = 0; a < NACT; a++)
               chk("R9", $sformatf("fire count a%0d", a), fcnt(a), f[a] % (1 << FCW));
            chk("R8", "free run err", int'(err_o), 0);
            done_i = fire_o;
            for (int a = 0; a < NACT; a++) if (fire_o[a]) dn[a]++;
         end
         chk("R3", "sink actor made progress", int'(f[2] > 10), 1);
         chk("R9", "counter wrapped", int'(f[0] > (1 << FCW)), 1);
         @(negedge clk);
         done_i = '0;
         fire_en_i = 1'b0;
      end

      // overflow via completion pulses with no firing
      do_reset();
      for (int p = 1; p <= 5; p++) begin
         done_i = 3'b001;
         @(negedge clk);
         done_i = '0;
         chk("R8", $sformatf("pulse %0d arc0", p), arc(0), (p <= 3) ? 2 * p : 6);
         chk("R8", $sformatf("pulse %0d err", p), int'(err_o), (p <= 3) ? 0 : 1);
      end
      chk("R8", "arc1 untouched", arc(1), 0);
      chk("R8", "arc2 untouched", arc(2), 2);
      @(negedge clk);
      chk("R8", "err still set", int'(err_o), 1);
      chk("R10", "no strobe with permit low", int'(fire_o), 0);

      do_reset();
      @(negedge clk);
      chk_reset_state();

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule